// File: doc/BRIEF.md
# Zero-Crossing-Triggered Temperature Conversion Sequencer

This block runs one on-chip temperature reading at a time. Software asks for a reading by writing a 1 into the request bit of a mode register. The request does not start the conversion. The block arms itself and waits for the next zero-crossing pulse from the second measurement channel. On that pulse it steers the first ADC channel's input multiplexer to the temperature sensor and holds it there for a fixed window of clock cycles.

At the end of the window the block stores the top byte of the filtered 24-bit signed ADC sample as a two's-complement temperature code, where 0x00 means about 25 °C. In the same cycle it clears the request bit and raises a one-cycle completion event for the interrupt logic. In the following cycle it gives the multiplexer back to the normal channel input. The analog front end and the decimation filter are outside the block. The filtered sample arrives on a port.

Top module: `zc_temp_seq`

## Requirements
- R1: While reset is held and after it is released, `tempReg`, `modeRdata`, `muxSelTemp`, `tempDone` and `tempIrq` are all zero.
- R2: A mode write in the idle state stores every bit of `modeWdata` in `modeRdata`. Bit 5 is the request bit, and writing it as 1 arms the sequencer.
- R3: A conversion starts on the first `zeroCross` pulse sampled at a clock edge after the edge that accepted the request. A pulse that comes in the same cycle as the request write is ignored.
- R4: `muxSelTemp` goes high in the cycle after the starting edge and stays high for exactly 96 cycles. It is low in the cycle after the capture edge.
- R5: On the capture edge, which is the 96th edge after the starting edge, `tempReg` takes `adcSample[23:16]` as present at that edge. At all other times `tempReg` holds its value.
- R6: Request bit 5 of `modeRdata` clears on the capture edge. A new request written afterwards is accepted.
- R7: `tempDone` is high for exactly the one cycle after the capture edge. `tempIrq` is high in that same cycle only if `tempIrqEn` was 1 at the capture edge.
- R8: While armed or converting, mode writes cannot change bit 5 (they still store the other bits), and `zeroCross` pulses during a conversion do not restart it or move the capture edge.
- R9: A `zeroCross` pulse while no request is pending has no effect: `muxSelTemp` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 16 | Mode register write data; bit 5 requests a reading |
| modeRdata | output | 16 | Mode register contents |
| zeroCross | input | 1 | One-cycle zero-crossing pulse from channel 2 |
| adcSample | input | 24 | Filtered signed channel 1 sample |
| tempIrqEn | input | 1 | Temperature interrupt enable (enable bit 5) |
| muxSelTemp | output | 1 | 1 routes the temperature sensor into channel 1 |
| tempReg | output | 8 | Signed temperature result |
| tempDone | output | 1 | One-cycle completion event |
| tempIrq | output | 1 | Completion event gated by the enable |

## Verification
A request is visible on `modeRdata` one cycle after its write edge. The multiplexer responds one cycle after the `zeroCross` edge. `tempReg`, `tempDone`, `tempIrq` and the cleared request bit all appear together one cycle after the 96th edge from the start. The bench drives inputs on falling edges and samples on falling edges. It checks the multiplexer at every one of the 96 cycles and presents the wanted sample only during the single cycle before the capture edge, with decoys on either side, so a capture one cycle early or late reads a wrong code. One cycle after the capture it checks again that `tempDone` has fallen and that `tempReg` held its value.

// File: rtl/zc_temp_pkg.sv
package zc_temp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2
  } seqState_e;

  // Strobes from the controller into the datapath; at most one per cycle.
  typedef struct packed {
    logic reqAccept;
    logic convStart;
    logic capture;
  } seqStrobe_t;

endpackage

// File: rtl/zc_temp_ctrl.sv
module zc_temp_ctrl
  import zc_temp_pkg::*;
#(
  parameter int CONV_CYCLES = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqWrite,
  input  logic       zeroCross,
  output seqStrobe_t strobe,
  output logic       muxSel
);

  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  seqState_e state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:  strobe.reqAccept = reqWrite;
      ST_ARMED: strobe.convStart = zeroCross;
      ST_CONV:  strobe.capture   = (cnt == LAST);
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      if (strobe.reqAccept) state <= ST_ARMED;
      if (strobe.convStart) begin
        state <= ST_CONV;
        cnt   <= '0;
      end
      if (state == ST_CONV) begin
        if (strobe.capture) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign muxSel = (state == ST_CONV);

  // R3: an armed zero crossing hands the mux to the sensor next cycle
  a_r3_start_on_zc: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && zeroCross) |=> muxSel);

  // R9: a zero crossing with nothing pending leaves the mux alone
  a_r9_idle_zc_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && zeroCross && !reqWrite) |=> !muxSel);

  // R8: a running conversion advances by one every cycle regardless of inputs
  a_r8_conv_undisturbed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !strobe.capture) |=>
      (state == ST_CONV && cnt == $past(cnt) + CNT_W'(1)));

  // R4: the window counter never passes its last step
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    muxSel |-> cnt <= LAST);

  // R4: mux released right after capture
  a_r4_mux_release: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !muxSel);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/zc_temp_dpath.sv
module zc_temp_dpath
  import zc_temp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int TEMP_W   = 8,
  parameter int MODE_W   = 16,
  parameter int REQ_BIT  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                modeWe,
  input  logic [MODE_W-1:0]   modeWdata,
  input  logic [SAMPLE_W-1:0] adcSample,
  input  logic                tempIrqEn,
  output logic [MODE_W-1:0]   modeReg,
  output logic [TEMP_W-1:0]   tempReg,
  output logic                tempDone,
  output logic                tempIrq
);

  localparam int LOW_W = SAMPLE_W - TEMP_W;

  logic [TEMP_W-1:0] sampleTop;
  logic sampleLowUnused;

  assign sampleTop       = adcSample[SAMPLE_W-1 -: TEMP_W];
  assign sampleLowUnused = ^adcSample[LOW_W-1:0];

  for (genvar b = 0; b < MODE_W; b++) begin : g_mode
    if (b == REQ_BIT) begin : g_req
      always_ff @(posedge clk) begin
        if (!rstN)                 modeReg[b] <= 1'b0;
        else if (strobe.capture)   modeReg[b] <= 1'b0;
        else if (strobe.reqAccept) modeReg[b] <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)       modeReg[b] <= 1'b0;
        else if (modeWe) modeReg[b] <= modeWdata[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempReg  <= '0;
      tempDone <= 1'b0;
      tempIrq  <= 1'b0;
    end else begin
      tempDone <= strobe.capture;
      tempIrq  <= strobe.capture & tempIrqEn;
      if (strobe.capture) tempReg <= sampleTop;
    end
  end

  // R5: captured code is the sample's top byte from the capture edge
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    tempDone |-> tempReg == $past(sampleTop));

  // R5: result holds between captures
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tempDone |-> $stable(tempReg));

  // R6: completion comes with the request bit cleared
  a_r6_req_cleared: assert property (@(posedge clk) disable iff (!rstN)
    tempDone |-> !modeReg[REQ_BIT]);

  // R2: an accepted request is visible next cycle
  a_r2_req_visible: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reqAccept |=> modeReg[REQ_BIT]);

  // R7: interrupt only with completion and enable
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    tempIrq |-> (tempDone && $past(tempIrqEn)));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tempDone |=> !tempDone);

endmodule

// File: rtl/zc_temp_seq.sv
module zc_temp_seq
  import zc_temp_pkg::*;
#(
  parameter int CONV_CYCLES = 96,
  parameter int SAMPLE_W    = 24,
  parameter int TEMP_W      = 8,
  parameter int MODE_W      = 16,
  parameter int REQ_BIT     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWe,
  input  logic [MODE_W-1:0]   modeWdata,
  output logic [MODE_W-1:0]   modeRdata,
  input  logic                zeroCross,
  input  logic [SAMPLE_W-1:0] adcSample,
  input  logic                tempIrqEn,
  output logic                muxSelTemp,
  output logic [TEMP_W-1:0]   tempReg,
  output logic                tempDone,
  output logic                tempIrq
);

  seqStrobe_t strobe;
  logic reqWrite;

  assign reqWrite = modeWe & modeWdata[REQ_BIT];

  zc_temp_ctrl #(
    .CONV_CYCLES(CONV_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqWrite (reqWrite),
    .zeroCross(zeroCross),
    .strobe   (strobe),
    .muxSel   (muxSelTemp)
  );

  zc_temp_dpath #(
    .SAMPLE_W(SAMPLE_W),
    .TEMP_W  (TEMP_W),
    .MODE_W  (MODE_W),
    .REQ_BIT (REQ_BIT)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modeWe   (modeWe),
    .modeWdata(modeWdata),
    .adcSample(adcSample),
    .tempIrqEn(tempIrqEn),
    .modeReg  (modeRdata),
    .tempReg  (tempReg),
    .tempDone (tempDone),
    .tempIrq  (tempIrq)
  );

endmodule

// File: tb/zc_temp_seq_tb_top.sv
module zc_temp_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWe = 1'b0;
  logic [15:0] modeWdata = '0;
  logic [15:0] modeRdata;
  logic        zeroCross = 1'b0;
  logic [23:0] adcSample = '0;
  logic        tempIrqEn = 1'b0;
  logic        muxSelTemp;
  logic [7:0]  tempReg;
  logic        tempDone;
  logic        tempIrq;

  int vecCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  zc_temp_seq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeWe    (modeWe),
    .modeWdata (modeWdata),
    .modeRdata (modeRdata),
    .zeroCross (zeroCross),
    .adcSample (adcSample),
    .tempIrqEn (tempIrqEn),
    .muxSelTemp(muxSelTemp),
    .tempReg   (tempReg),
    .tempDone  (tempDone),
    .tempIrq   (tempIrq)
  );

  localparam int NVEC = 4;
  localparam logic [23:0] V_SAMPLE [NVEC] = '{24'h123456, 24'hF30001, 24'h00FFFF, 24'h800000};
  localparam logic [7:0]  V_TEMP   [NVEC] = '{8'h12, 8'hF3, 8'h00, 8'h80};
  localparam logic [15:0] V_MODE   [NVEC] = '{16'h0020, 16'h00A5, 16'hFFFF, 16'h0021};
  localparam logic        V_IEN    [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          V_WAIT   [NVEC] = '{0, 3, 10, 1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic modeWrite(input logic [15:0] d);
    modeWe = 1'b1;
    modeWdata = d;
    cyc();
    modeWe = 1'b0;
  endtask

  // Pulses zeroCross on an armed sequencer and checks the full window.
  // injectAt > 0: at that step write 0 to the mode register and pulse zeroCross.
  task automatic convAndCheck(input logic [23:0] target, input logic [7:0] expTemp,
                              input logic ien, input logic [15:0] expModeAfter,
                              input int injectAt);
    tempIrqEn = ien;
    adcSample = ~target;
    zeroCross = 1'b1;
    cyc();
    zeroCross = 1'b0;
    chk("R3 mux after zc", 32'(muxSelTemp), 32'd1);
    for (int s = 1; s < 96; s++) begin
      if (s == injectAt) begin
        modeWe = 1'b1;
        modeWdata = 16'h0000;
        zeroCross = 1'b1;
      end
      cyc();
      modeWe = 1'b0;
      zeroCross = 1'b0;
      chk("R4 mux in window", 32'(muxSelTemp), 32'd1);
      chk("R7 no early done", 32'(tempDone), 32'd0);
      if (s == injectAt)
        chk("R8 req bit kept", 32'(modeRdata), 32'h0020);
    end
    adcSample = target;
    cyc();
    adcSample = ~target;
    chk("R4 mux released", 32'(muxSelTemp), 32'd0);
    chk("R5 temp captured", 32'(tempReg), 32'(expTemp));
    chk("R7 done pulse", 32'(tempDone), 32'd1);
    chk("R7 irq gated", 32'(tempIrq), 32'(ien));
    chk("R6 req cleared", 32'(modeRdata), 32'(expModeAfter));
    cyc();
    chk("R7 done single", 32'(tempDone), 32'd0);
    chk("R7 irq single", 32'(tempIrq), 32'd0);
    chk("R5 temp held", 32'(tempReg), 32'(expTemp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc();
    chk("R1 reset temp", 32'(tempReg), 32'd0);
    chk("R1 reset mode", 32'(modeRdata), 32'd0);
    chk("R1 reset mux", 32'(muxSelTemp), 32'd0);
    chk("R1 reset done", 32'(tempDone), 32'd0);
    rstN = 1'b1;
    cyc();
    chk("R1 after release", 32'({muxSelTemp, tempDone, tempIrq, tempReg, modeRdata}), 32'd0);

    // Table walk: request, wait, convert, capture.
    for (int v = 0; v < NVEC; v++) begin
      modeWrite(V_MODE[v]);
      chk("R2 R6 mode stored", 32'(modeRdata), 32'(V_MODE[v]));
      repeat (V_WAIT[v]) begin
        cyc();
        chk("R3 waits for zc", 32'(muxSelTemp), 32'd0);
      end
      convAndCheck(V_SAMPLE[v], V_TEMP[v], V_IEN[v], V_MODE[v] & ~16'h0020, 0);
    end

    // R9: zero crossing without a request does nothing.
    zeroCross = 1'b1;
    cyc();
    zeroCross = 1'b0;
    chk("R9 idle zc mux", 32'(muxSelTemp), 32'd0);
    cyc();
    chk("R9 idle zc mux later", 32'(muxSelTemp), 32'd0);

    // R3: zc in the same cycle as the request write is ignored.
    modeWdata = 16'h0020;
    modeWe = 1'b1;
    zeroCross = 1'b1;
    cyc();
    modeWe = 1'b0;
    zeroCross = 1'b0;
    chk("R3 same-cycle zc mux", 32'(muxSelTemp), 32'd0);
    cyc();
    chk("R3 same-cycle zc still armed", 32'(muxSelTemp), 32'd0);
    chk("R3 armed req bit", 32'(modeRdata), 32'h0020);

    // R8: write of 0 and extra zc mid-conversion do not cancel or restart.
    convAndCheck(24'h7FABCD, 8'h7F, 1'b1, 16'h0000, 40);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule